// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block receives stereo PCM audio in slave mode. An external master supplies the bit clock, the word-select (frame) clock and one or more serial data lanes. The receiver samples every lane on the rising edge of the bit clock, finds the subframe boundaries from the word-select level changes and assembles each subframe, most-significant bit first, into a parallel sample. The `fmt_lj` input selects the framing. With I2S framing, the data lags word select by one bit and the left channel is carried while word select is low. With left-justified framing, there is no lag and the left channel is carried while word select is high.

All lanes share one clock pair. One strobe therefore delivers the same subframe position of every lane at once, tagged as left or right. The sample width is set by `word_len`. Slots after the configured width are discarded. A subframe that is shorter than the width has zeros in its low bits. The whole block runs in the bit-clock domain. Moving samples into another clock domain is left to the surrounding logic.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held and after its release, `smp_valid` stays low and `smp_data` stays zero until the first subframe has been delivered.
- R2: Left-justified mode (`fmt_lj`=1): the bit sampled on the same rising edge at which `ws` first shows its new level is the MSB of the new subframe. Later bits follow MSB first, one per rising edge.
- R3: I2S mode (`fmt_lj`=0): the MSB of a subframe is the bit sampled one rising edge after the edge at which `ws` first shows its new level. The bit sampled on that first edge is the last slot of the previous subframe.
- R4: In I2S mode, a subframe received while `ws`=0 is tagged left (`smp_right`=0), and one received while `ws`=1 is tagged right (`smp_right`=1).
- R5: In left-justified mode, a subframe received while `ws`=1 is tagged left (`smp_right`=0), and one received while `ws`=0 is tagged right (`smp_right`=1).
- R6: The sample width is `word_len`, from 1 to MAX_W. A value of 0 or above MAX_W acts as MAX_W. Each lane's sample is right-justified in its MAX_W-bit field: the MSB sits at bit `word_len`-1 and all bits above it are zero.
- R7: Slots of a subframe that come after the first `word_len` bits have no effect on the delivered sample.
- R8: A subframe that carries fewer slots than `word_len` is delivered with its received bits at the top of the sample and zeros in the remaining low bits.
- R9: Each completed subframe is delivered with a one-cycle `smp_valid` pulse. The pulse follows the rising edge that begins the next subframe. Lane n occupies `smp_data` bits [n*MAX_W +: MAX_W].
- R10: Bits received before the first subframe boundary after reset are never delivered. The first pulse after reset carries the first complete subframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock from the external master; every register uses its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ws | input | 1 | Word-select (frame) clock from the master |
| sd | input | LANES | Serial data lanes, one bit per lane |
| fmt_lj | input | 1 | Framing select: 0 = I2S, 1 = left-justified |
| word_len | input | $clog2(MAX_W+1) | Sample width in bits |
| smp_valid | output | 1 | One-cycle strobe marking a delivered subframe |
| smp_right | output | 1 | Channel tag of the delivered subframe: 0 = left, 1 = right |
| smp_data | output | LANES*MAX_W | Samples of all lanes, lane 0 in the low field |

## Verification
The bench builds the receiver with its defaults: four lanes and a 32-bit field. This lets it compare four independent random lanes in every strobe and reach the widest sample width. Frames of 3, 12, 16, 32 and 40 slots per subframe are sent under widths of 1, 16, 20, 24 and 32 bits and the out-of-range value 0. This covers truncation, zero padding and the exact-fit case in both framings. Each run starts from reset, so the first-boundary behaviour is checked in every framing and width combination.

// File: rtl/sa_rx_pkg.sv
package sa_rx_pkg;
    typedef enum logic {
        FMT_I2S = 1'b0,
        FMT_LJ  = 1'b1
    } frame_fmt_e;
endpackage

// File: rtl/sa_frame_tracker.sv
module sa_frame_tracker #(
    parameter int MAX_W = 32,
    parameter int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ws,
    input  logic             fmt_lj,
    input  logic [LEN_W-1:0] word_len,
    output logic             start,
    output logic             take,
    output logic             emit,
    output logic             cur_right,
    output logic [LEN_W-1:0] bit_pos,
    output logic [LEN_W-1:0] eff_len
);
    import sa_rx_pkg::*;

    typedef struct packed {
        logic             ws;
        logic             seen;
        logic             trans;
        logic             active;
        logic             right;
        logic [LEN_W-1:0] cnt;
    } trk_t;

    trk_t s_d, s_q;
    logic trans;
    logic is_lj;

    always_comb begin
        is_lj   = (frame_fmt_e'(fmt_lj) == FMT_LJ);
        eff_len = ((word_len == '0) || (word_len > LEN_W'(MAX_W))) ? LEN_W'(MAX_W) : word_len;
        // a level change seen on this edge versus the previous one
        trans   = s_q.seen && (ws != s_q.ws);
        // left-justified begins on the change, I2S one edge later
        start   = is_lj ? trans : s_q.trans;
        emit    = start && s_q.active;
        take    = start || (s_q.active && (s_q.cnt < eff_len));
        bit_pos = start ? (eff_len - LEN_W'(1)) : (eff_len - LEN_W'(1) - s_q.cnt);
        cur_right = s_q.right;

        s_d       = s_q;
        s_d.ws    = ws;
        s_d.seen  = 1'b1;
        s_d.trans = trans;
        if (start) begin
            s_d.active = 1'b1;
            s_d.cnt    = LEN_W'(1);
            s_d.right  = is_lj ? ~ws : s_q.ws;
        end else if (take) begin
            s_d.cnt = s_q.cnt + LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7: the slot counter never runs past the configured width
    assert_len_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= eff_len);

    // R6: a written slot always lands inside the sample field
    assert_pos_in_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (bit_pos < eff_len));
endmodule

// File: rtl/sa_lane_deser.sv
module sa_lane_deser #(
    parameter int MAX_W = 32,
    parameter int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sd,
    input  logic             start,
    input  logic             take,
    input  logic [LEN_W-1:0] bit_pos,
    output logic [MAX_W-1:0] word
);
    localparam int IDX_W = (MAX_W > 1) ? $clog2(MAX_W) : 1;

    logic [MAX_W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (start) acc_d = '0;
        if (take)  acc_d[bit_pos[IDX_W-1:0]] = sd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign word = acc_q;
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
    parameter int LANES = 4,
    parameter int MAX_W = 32,
    parameter int LEN_W = $clog2(MAX_W + 1)
) (
    input  logic                   bclk,
    input  logic                   rst_n,
    input  logic                   ws,
    input  logic [LANES-1:0]       sd,
    input  logic                   fmt_lj,
    input  logic [LEN_W-1:0]       word_len,
    output logic                   smp_valid,
    output logic                   smp_right,
    output logic [LANES*MAX_W-1:0] smp_data
);
    localparam int DATA_W = LANES * MAX_W;

    typedef struct packed {
        logic              valid;
        logic              right;
        logic [DATA_W-1:0] data;
    } out_t;

    logic             start, take, emit, cur_right;
    logic [LEN_W-1:0] bit_pos, eff_len;
    logic [DATA_W-1:0] lane_words;
    out_t o_d, o_q;

    sa_frame_tracker #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_trk (
        .clk(bclk), .rst_n(rst_n), .ws(ws), .fmt_lj(fmt_lj), .word_len(word_len),
        .start(start), .take(take), .emit(emit), .cur_right(cur_right),
        .bit_pos(bit_pos), .eff_len(eff_len)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sa_lane_deser #(.MAX_W(MAX_W), .LEN_W(LEN_W)) u_lane (
            .clk(bclk), .rst_n(rst_n), .sd(sd[g]), .start(start), .take(take),
            .bit_pos(bit_pos), .word(lane_words[g*MAX_W +: MAX_W])
        );

        // R6: nothing above the sample width in any lane field
        assert_upper_zero_R6: assert property (@(posedge bclk) disable iff (!rst_n)
            smp_valid |-> ((smp_data[g*MAX_W +: MAX_W] >> eff_len) == '0));
    end

    always_comb begin
        o_d       = o_q;
        o_d.valid = emit;
        if (emit) begin
            o_d.right = cur_right;
            o_d.data  = lane_words;
        end
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign smp_valid = o_q.valid;
    assign smp_right = o_q.right;
    assign smp_data  = o_q.data;

    // R9: delivery strobe lasts exactly one cycle
    assert_single_pulse_R9: assert property (@(posedge bclk) disable iff (!rst_n)
        smp_valid |=> !smp_valid);

    // R4: I2S tag is the opposite of the word-select level now in force
    assert_i2s_chan_R4: assert property (@(posedge bclk) disable iff (!rst_n)
        (smp_valid && !fmt_lj) |-> (smp_right == !ws));

    // R5: left-justified tag equals the word-select level now in force
    assert_lj_chan_R5: assert property (@(posedge bclk) disable iff (!rst_n)
        (smp_valid && fmt_lj) |-> (smp_right == ws));
endmodule

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;
    localparam int LANES = 4;
    localparam int MAX_W = 32;
    localparam int LEN_W = $clog2(MAX_W + 1);

    logic                   bclk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   ws = 1'b0;
    logic [LANES-1:0]       sd = '0;
    logic                   fmt_lj = 1'b0;
    logic [LEN_W-1:0]       word_len = LEN_W'(24);
    logic                   smp_valid, smp_right;
    logic [LANES*MAX_W-1:0] smp_data;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_tag = "";
    logic [LANES-1:0] lj_prev = '0;
    logic [LANES*MAX_W:0] exp_q[$];
    bit    prev_valid = 1'b0;

    always #10 bclk = ~bclk;

    serial_audio_rx #(.LANES(LANES), .MAX_W(MAX_W)) u_dut (
        .bclk(bclk), .rst_n(rst_n), .ws(ws), .sd(sd), .fmt_lj(fmt_lj),
        .word_len(word_len), .smp_valid(smp_valid), .smp_right(smp_right),
        .smp_data(smp_data)
    );

    // monitor: compares every strobe with the scoreboard
    always @(negedge bclk) begin
        if (rst_n) begin
            if (smp_valid) begin
                logic [LANES*MAX_W:0] e;
                n_checks++;
                if (prev_valid) begin
                    n_fail++;
                    $display("FAIL R9 strobe width: actual 2+ cycles expected 1");
                end
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R10 unexpected strobe: actual data %h expected none", smp_data);
                end else begin
                    e = exp_q.pop_front();
                    if (smp_right != e[LANES*MAX_W]) begin
                        n_fail++;
                        $display("FAIL %s channel tag: actual %0d expected %0d",
                                 fmt_lj ? "R5" : "R4", smp_right, e[LANES*MAX_W]);
                    end
                    if (smp_data != e[LANES*MAX_W-1:0]) begin
                        n_fail++;
                        $display("FAIL %s data: actual %h expected %h",
                                 cur_tag, smp_data, e[LANES*MAX_W-1:0]);
                    end
                end
            end
            prev_valid = smp_valid;
        end else begin
            prev_valid = 1'b0;
        end
    end

    // driver: one subframe of h slots; expected result pushed when asked
    task automatic send_sub(input bit right, input int h, input bit push);
        logic [63:0] word [LANES];
        logic [LANES*MAX_W-1:0] exp_data;
        logic [63:0] e;
        logic [LANES-1:0] cur;
        int wl;
        wl = ((word_len == 0) || (int'(word_len) > MAX_W)) ? MAX_W : int'(word_len);
        for (int l = 0; l < LANES; l++) begin
            word[l] = {$urandom, $urandom} & ((64'd1 << h) - 64'd1);
            e = (h >= wl) ? (word[l] >> (h - wl)) : (word[l] << (wl - h));
            exp_data[l*MAX_W +: MAX_W] = e[MAX_W-1:0];
        end
        if (push) exp_q.push_back({right, exp_data});
        for (int j = 0; j < h; j++) begin
            @(negedge bclk);
            for (int l = 0; l < LANES; l++) cur[l] = word[l][h-1-j];
            ws <= fmt_lj ? ~right : right;
            sd <= fmt_lj ? cur : lj_prev;
            lj_prev = cur;
        end
    endtask

    task automatic run_group(input bit lj, input int wl, input int h, input int nsub,
                             input string tag);
        @(negedge bclk);
        rst_n    <= 1'b0;
        fmt_lj   <= lj;
        word_len <= LEN_W'(wl);
        ws       <= lj ? 1'b0 : 1'b1;   // idle at the right-channel level
        sd       <= '1;                 // junk before the first boundary (R10)
        lj_prev   = '1;
        cur_tag   = tag;
        repeat (3) @(negedge bclk);
        rst_n <= 1'b1;
        repeat (3) @(negedge bclk);
        n_checks++;
        if (smp_valid !== 1'b0 || smp_data !== '0) begin
            n_fail++;
            $display("FAIL R1 idle after reset: actual valid %b data %h expected 0 and 0",
                     smp_valid, smp_data);
        end
        for (int k = 0; k < nsub; k++) send_sub(k[0], h, 1'b1);
        send_sub(nsub[0], h, 1'b0);
        repeat (4) @(negedge bclk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R9 R10 undelivered subframes: actual %0d expected 0", exp_q.size());
            exp_q.delete();
        end
    endtask

    initial begin
        repeat (100000) @(posedge bclk);
        n_fail++;
        $display("FAIL watchdog: actual run still busy expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        run_group(1'b0, 24, 32, 6, "R3 R6 R7");  // I2S, truncation
        run_group(1'b1, 24, 32, 6, "R2 R6 R7");  // left-justified, truncation
        run_group(1'b0, 16, 12, 6, "R3 R8");     // I2S, zero padding
        run_group(1'b1, 20, 16, 6, "R2 R8");     // left-justified, zero padding
        run_group(1'b1,  0, 32, 6, "R2 R6");     // width 0 acts as full width
        run_group(1'b0, 32, 40, 6, "R3 R7");     // I2S, full width, long slots
        run_group(1'b1,  1,  3, 6, "R2 R7");     // single-bit samples
        run_group(1'b0, 32, 32, 6, "R3 R4 R6");  // I2S exact fit
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule